// File: doc/BRIEF.md
# Sensor-ADC mode command sequencer

This block switches an external power-sensing converter and GPIO companion chip into a streaming mode. It does so by sending one 16-bit command through a frame engine that shifts SPI data. A request carries three values: a mode code, the number of ADC channels to stream and the number of GPIO ports to stream. A valid request makes the sequencer poll the frame engine's busy flag until the engine is idle. It then builds the mode word, launches the frame with a one-cycle start pulse and waits a fixed settle time before it signals completion.

Every wait is counted in microsecond ticks, taken from a parameter that gives the number of clock cycles per microsecond. Completion is a one-cycle done pulse. The error code that goes with it holds its value until the next completion. An unknown mode code is rejected at once, and no frame is sent. A frame engine that stays busy through every poll gives a timeout.

Top module: `sad_mode_seq`

## Requirements
- R1: After synchronous reset, spi_start_o, done_o and busy_o are low, err_o is 0 (ok) and spi_data_o is 0.
- R2: Mode code 0 (composite) sends a word whose bits 15..10 are 100011 and whose bits 9..6 hold the channel count minus one, modulo 16. Bits 5..2 are 0 and bits 1..0 hold the port count.
- R3: In the composite word only the two low bits of gpio_cnt_i are used. Its higher bits have no effect on the word.
- R4: Mode code 1 (auto2) sends the fixed word 0x3FC0, whatever the counts are.
- R5: Mode codes 2 and 3 are invalid. For these, done_o rises in the cycle after the request is accepted, with err_o = 2, and no start pulse is issued.
- R6: The busy flag is first sampled at the first clock edge after acceptance. While it stays high it is sampled again every CLK_PER_US+1 cycles, for at most POLL_TRIES samples in total. The launch follows the first sample that sees the engine idle.
- R7: If all POLL_TRIES samples see busy, done_o rises with err_o = 1 and no start pulse is issued. This happens POLL_TRIES + (POLL_TRIES-1)*CLK_PER_US cycles after acceptance.
- R8: After a launch, done_o rises with err_o = 0 exactly SETTLE_US*CLK_PER_US+1 cycles after the start pulse. Busy is not sampled during that time.
- R9: spi_start_o is a one-cycle pulse, issued once per valid request, and spi_data_o holds the command word while it is high.
- R10: A start request that arrives while busy_o is high is ignored. The launch count, the word and the timing stay as they were for the first request.
- R11: done_o lasts one cycle, and err_o changes only in a cycle where done_o is high. busy_o is high from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken when idle |
| mode_i | input | 2 | Mode code: 0 composite, 1 auto2, others invalid |
| adc_cnt_i | input | 5 | Number of ADC channels to stream (1..16) |
| gpio_cnt_i | input | 4 | Number of GPIO ports to stream (low two bits used) |
| spi_busy_i | input | 1 | Frame engine busy flag |
| spi_start_o | output | 1 | One-cycle frame launch pulse |
| spi_data_o | output | 16 | Command word for the frame engine |
| busy_o | output | 1 | Sequencer is working on a request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 0 ok, 1 timeout, 2 invalid mode |

## Verification
The busy release point is placed on both sides of the last poll. Releasing it at the final sample must still launch, and releasing it one cycle later must time out. An off-by-one poll counter would turn one of these into the wrong outcome. The port count is driven with its high bits set, to expose a design that lets them leak into the channel field. The channel count is driven at 1 and at 16, to expose a missing subtract or a wrong field position. The bench pokes start_i during the settle time, which would show a design that restarts or launches twice. It measures the distance from launch to done in cycles, which catches a settle counter that is too short, or one that polls busy again.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int MODE_W   = 2;
    localparam int ADC_CW   = 5;
    localparam int GPIO_CW  = 4;
    localparam int WORD_W   = 16;

    localparam logic [MODE_W-1:0] MODE_COMPOSITE = 2'd0;
    localparam logic [MODE_W-1:0] MODE_AUTO2     = 2'd1;

    localparam logic [5:0]        COMP_HEAD  = 6'b100011;
    localparam logic [WORD_W-1:0] AUTO2_WORD = 16'h3FC0;

    typedef enum logic [1:0] {
        ERR_OK      = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_MODE    = 2'd2
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_GAP,
        ST_LAUNCH,
        ST_SETTLE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } cmd_t;

    function automatic cmd_t make_cmd(input logic [MODE_W-1:0]  mode,
                                      input logic [ADC_CW-1:0]  adc_cnt,
                                      input logic [GPIO_CW-1:0] gpio_cnt);
        cmd_t             c;
        logic [ADC_CW-1:0] last;
        last = adc_cnt - 1'b1;
        c.valid = 1'b1;
        case (mode)
            MODE_COMPOSITE: c.word = {COMP_HEAD, last[3:0], 4'b0000, gpio_cnt[1:0]};
            MODE_AUTO2:     c.word = AUTO2_WORD;
            default: begin
                c.word  = '0;
                c.valid = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sad_us_timer.sv
module sad_us_timer #(
    parameter int CLK_PER_US = 200,
    parameter int MAX_US     = 20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           run_i,
    input  logic [$clog2(MAX_US+1)-1:0]    target_us_i,
    output logic                           expire_o
);
    localparam int CYC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam int US_W  = $clog2(MAX_US + 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_US - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [US_W-1:0]  us_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cyc_q <= '0;
            us_q  <= '0;
        end else if (cyc_q == CYC_LAST) begin
            cyc_q <= '0;
            us_q  <= us_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cyc_q == CYC_LAST) && (us_q == target_us_i - 1'b1);

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (rst)
        cyc_q <= CYC_LAST); // R6

    AST_US_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (us_q < target_us_i)); // R8

endmodule

// File: rtl/sad_cmd_word.sv
module sad_cmd_word
    import sad_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [ADC_CW-1:0]  adc_cnt_i,
    input  logic [GPIO_CW-1:0] gpio_cnt_i,
    output cmd_t               cmd_o
);
    always_comb begin
        cmd_o = make_cmd(mode_i, adc_cnt_i, gpio_cnt_i);
    end
endmodule

// File: rtl/sad_mode_seq.sv
module sad_mode_seq
    import sad_pkg::*;
#(
    parameter int CLK_PER_US = 200,
    parameter int POLL_TRIES = 10,
    parameter int SETTLE_US  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [4:0]         adc_cnt_i,
    input  logic [3:0]         gpio_cnt_i,
    input  logic               spi_busy_i,
    output logic               spi_start_o,
    output logic [15:0]        spi_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [1:0]         err_o
);
    localparam int TRY_W = $clog2(POLL_TRIES + 1);
    localparam int US_W  = $clog2(SETTLE_US + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES - 1);

    seq_state_e        st_q;
    logic [TRY_W-1:0]  tries_q;
    logic [WORD_W-1:0] word_q;
    err_e              err_q;
    cmd_t              cmd;
    logic              tmr_run;
    logic              tmr_exp;
    logic [US_W-1:0]   tmr_target;

    sad_cmd_word u_word (
        .mode_i     (mode_i),
        .adc_cnt_i  (adc_cnt_i),
        .gpio_cnt_i (gpio_cnt_i),
        .cmd_o      (cmd)
    );

    assign tmr_run    = (st_q == ST_GAP) || (st_q == ST_SETTLE);
    assign tmr_target = (st_q == ST_SETTLE) ? US_W'(SETTLE_US) : US_W'(1);

    sad_us_timer #(
        .CLK_PER_US (CLK_PER_US),
        .MAX_US     (SETTLE_US)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .run_i       (tmr_run),
        .target_us_i (tmr_target),
        .expire_o    (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tries_q <= '0;
            word_q  <= '0;
            err_q   <= ERR_OK;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (cmd.valid) begin
                            word_q  <= cmd.word;
                            tries_q <= '0;
                            st_q    <= ST_POLL;
                        end else begin
                            err_q <= ERR_MODE;
                            st_q  <= ST_FIN;
                        end
                    end
                end
                ST_POLL: begin
                    if (!spi_busy_i) begin
                        st_q <= ST_LAUNCH;
                    end else if (tries_q == TRY_LAST) begin
                        err_q <= ERR_TIMEOUT;
                        st_q  <= ST_FIN;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        st_q    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tmr_exp) st_q <= ST_POLL;
                end
                ST_LAUNCH: st_q <= ST_SETTLE;
                ST_SETTLE: begin
                    if (tmr_exp) begin
                        err_q <= ERR_OK;
                        st_q  <= ST_FIN;
                    end
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign spi_start_o = (st_q == ST_LAUNCH);
    assign spi_data_o  = word_q;
    assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_FIN);
    assign done_o      = (st_q == ST_FIN);
    assign err_o       = err_q;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        spi_start_o |=> !spi_start_o); // R9

    AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        spi_start_o |-> $past(!spi_busy_i)); // R6

    AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !done_o && start_i && (mode_i > 2'd1)) |=> (done_o && err_o == 2'd2)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R11

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(err_o)); // R11

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(spi_data_o)); // R10

endmodule

// File: tb/sad_mode_seq_tb.sv
module sad_mode_seq_tb;

    localparam int CPU    = 20;
    localparam int TRIES  = 10;
    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [4:0]  adc_cnt_i = 5'd1;
    logic [3:0]  gpio_cnt_i = '0;
    logic        spi_busy_i = 1'b0;
    logic        spi_start_o;
    logic [15:0] spi_data_o;
    logic        busy_o;
    logic        done_o;
    logic [1:0]  err_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    sad_mode_seq #(
        .CLK_PER_US (CPU),
        .POLL_TRIES (TRIES),
        .SETTLE_US  (SETTLE)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .adc_cnt_i   (adc_cnt_i),
        .gpio_cnt_i  (gpio_cnt_i),
        .spi_busy_i  (spi_busy_i),
        .spi_start_o (spi_start_o),
        .spi_data_o  (spi_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int m, input int adc, input int gp);
        int last;
        last = (adc - 1) & 15;
        if (m == 0) return (6'b100011 << 10) | (last << 6) | (gp & 3);
        return 16'h3FC0;
    endfunction

    task automatic run_case(input int m, input int adc, input int gp, input int dly,
                            input bit poke, input string tag);
        int  rel, n_launch, launch_rel, done_rel, got_err, got_word, j;
        int  e_launch_rel, e_done_rel, e_err, e_launch;
        bit  finished, busy_seen;
        n_launch = 0; launch_rel = -1; done_rel = -1; got_err = -1; got_word = -1;
        finished = 0; busy_seen = 0;
        if (m > 1) begin
            e_err = 2; e_launch = 0; e_done_rel = 0; e_launch_rel = -1;
        end else begin
            j = (dly + CPU) / (CPU + 1);
            if (j <= TRIES - 1) begin
                e_err = 0; e_launch = 1;
                e_launch_rel = 1 + j * (CPU + 1);
                e_done_rel = e_launch_rel + SETTLE * CPU + 1;
            end else begin
                e_err = 1; e_launch = 0; e_launch_rel = -1;
                e_done_rel = TRIES + (TRIES - 1) * CPU;
            end
        end
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(m); adc_cnt_i = 5'(adc); gpio_cnt_i = 4'(gp);
        spi_busy_i = (dly > 0);
        @(posedge clk);
        rel = 0;
        while (!finished && rel < 5000) begin
            @(negedge clk);
            start_i = poke && (rel == 3 || rel == 40);
            if (poke) begin mode_i = 2'd1; adc_cnt_i = 5'd3; gpio_cnt_i = 4'd1; end
            spi_busy_i = (rel < dly);
            if (rel == 2 && busy_o) busy_seen = 1;
            if (spi_start_o) begin
                n_launch++; launch_rel = rel; got_word = spi_data_o;
            end
            if (done_o) begin
                done_rel = rel; got_err = err_o; finished = 1;
            end
            if (!finished) begin
                @(posedge clk);
                rel++;
            end
        end
        start_i = 1'b0; spi_busy_i = 1'b0;
        chk(done_rel == e_done_rel, {tag, " done timing R6 R7 R8"}, done_rel, e_done_rel);
        chk(got_err == e_err, {tag, " error code R5 R7 R8"}, got_err, e_err);
        chk(n_launch == e_launch, {tag, " launch count R9 R10"}, n_launch, e_launch);
        if (e_launch == 1) begin
            chk(launch_rel == e_launch_rel, {tag, " poll spacing R6"}, launch_rel, e_launch_rel);
            chk(got_word == exp_word(m, adc, gp), {tag, " word R2 R3 R4"}, got_word, exp_word(m, adc, gp));
        end
        if (m <= 1) chk(busy_seen, {tag, " busy_o during request R11"}, busy_seen, 1);
        @(negedge clk);
        chk(!done_o, {tag, " done one cycle R11"}, done_o, 0);
        chk(err_o == 2'(e_err), {tag, " err held R11"}, err_o, e_err);
        chk(!busy_o && !spi_start_o, {tag, " quiet after done R10"}, busy_o, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int m, adc, gp, dly;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!spi_start_o && !done_o && !busy_o, "reset outputs R1", {spi_start_o, done_o, busy_o}, 0);
        chk(err_o == 2'd0 && spi_data_o == 16'h0, "reset err/data R1", spi_data_o, 0);
        rst = 1'b0;
        @(negedge clk);

        run_case(0, 16, 3, 0, 0, "composite 16ch R2");
        run_case(0, 1, 0, 5, 0, "composite 1ch R2");
        run_case(0, 7, 14, 0, 0, "gpio high bits R3");
        run_case(1, 9, 2, 30, 0, "auto2 R4");
        run_case(2, 4, 1, 0, 0, "invalid 2 R5");
        run_case(3, 4, 1, 0, 0, "invalid 3 R5");
        run_case(0, 5, 2, 9 * (CPU + 1), 0, "last poll idle R6");
        run_case(0, 5, 2, 9 * (CPU + 1) + 1, 0, "one past last poll R7");
        run_case(1, 2, 0, 100000, 0, "stuck busy R7");
        run_case(0, 12, 1, 0, 1, "start ignored R10");
        run_case(0, 3, 2, 50, 1, "start ignored polling R10");

        for (int i = 0; i < 10; i++) begin
            m   = $urandom % 4;
            adc = 1 + ($urandom % 16);
            gp  = $urandom % 16;
            dly = ($urandom % 2 == 0) ? 0 : ($urandom % (10 * (CPU + 1) + 20));
            run_case(m, adc, gp, dly, 0, "random R2 R6");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule